// File: doc/BRIEF.md
# SPI Slave Transfer Engine

This block is the slave end of a four-wire serial peripheral link. An external master supplies the serial clock, the data line into the slave and an active-low select; the block returns data on its own output line, shifting out and in at the same time through a single shift register. The clock idle level, the sampling phase, the bit order and a word length of 8 or 16 bits are all configurable. All serial inputs are brought into the system clock domain through two-flop synchronizers, and edges are detected there. The system clock must run at least four times faster than the serial clock.

On the parallel side, a load pulse places a word in a transmit holding register. That word is copied into the shift register at the moment the select goes low. When a full word has been received, it is written to a receive register and a sticky done flag is raised. The flag stays set until a clear pulse arrives. One word is exchanged per select assertion. A select that is released early throws away the partial word.

The configuration inputs are sampled when the select falls and are held for the rest of the frame. The master may therefore not rely on changing the mode while a word is in flight. When the select is high, the output line is released: the output enable is low.

Top module: `spi_slave_xfer`

## Requirements
- R1: After reset, rx_word is 0, rx_done is 0 and miso_oe is 0.
- R2: Once the select input has been high for at least five system clocks, miso_oe is 0.
- R3: With phase 0 (cfg_cpha=0), miso_oe rises and bit 0 of the word appears on miso_out after the select falls and before any clock edge. Each later bit appears after each even edge. The data input is sampled on odd edges.
- R4: With phase 1 (cfg_cpha=1), miso_oe stays 0 until the first clock edge. Bit k appears after edge 2k+1, and the data input is sampled on even edges.
- R5: cfg_cpol gives the idle level of the serial clock. The odd-numbered edges are the ones leaving the idle level, for either polarity.
- R6: cfg_lsb_first=0 sends bit n-1 first, and the first received bit lands in bit n-1 of rx_word. cfg_lsb_first=1 sends bit 0 first, and the first received bit lands in bit 0.
- R7: cfg_wide=1 selects 16-bit words. cfg_wide=0 selects 8-bit words that use tx_word[7:0], with rx_word[15:8] reading 0.
- R8: A word is complete on edge 2n of the frame (n = word length). At that point rx_word takes the received word and rx_done is set. rx_word does not change at any other time.
- R9: rx_done stays 1 until a done_clr pulse clears it. A done_clr in the same cycle as a completion leaves rx_done at 1.
- R10: If the select rises before edge 2n, neither rx_word nor rx_done changes.
- R11: Polarity, phase, bit order and width are sampled when the select falls. Changing them later in the frame has no effect on that frame.
- R12: The transmitted word is the one in the holding register when the select falls. A tx_load during a frame affects only the next frame.
- R13: Clock edges after completion and before the select rises start no new word and do not set rx_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Sampling phase: 0 samples on odd edges, 1 on even edges |
| cfg_lsb_first | input | 1 | Bit order: 0 MSB first, 1 LSB first |
| cfg_wide | input | 1 | Word length: 0 is 8 bits, 1 is 16 bits |
| tx_word | input | 16 | Word to be sent in the next frame |
| tx_load | input | 1 | Writes tx_word into the transmit holding register |
| done_clr | input | 1 | Clears rx_done |
| sck_in | input | 1 | Serial clock from the master |
| mosi_in | input | 1 | Serial data from the master |
| ss_n_in | input | 1 | Active-low select from the master |
| rx_word | output | 16 | Last completed received word |
| rx_done | output | 1 | Sticky word-complete flag |
| miso_out | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for miso_out; low means released |

## Verification
The assertions assume that the serial inputs are slow compared with the system clock. Each level of the serial clock must last several system clocks, so that every edge is seen exactly once after synchronization. The data input must be stable for at least one half period around each sampling edge. The stimulus drives every serial clock level for eight system clocks and changes the data input only on the edge opposite the sampling edge. It drops the select at least eight clocks before the first edge, and it releases the select only after the last edge has settled.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
    logic wide;
  } spi_cfg_t;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int          STAGES  = 2,
  parameter int          N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[i]}};
        else     chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge
  import spi_slv_pkg::*;
#(
  parameter int W_WIDE   = 16,
  parameter int W_NARROW = 8,
  localparam int CNT_W   = $clog2(2*W_WIDE+1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sck_s,
  input  logic             frame_start,
  input  logic             run,
  input  spi_cfg_t         cfg,
  output logic             edge_evt,
  output logic             cap_evt,
  output logic             shf_evt,
  output logic             done_evt,
  output logic [CNT_W-1:0] edge_cnt
);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(2*W_WIDE);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(2*W_NARROW);

  logic             sck_d;
  logic             odd_edge;
  logic [CNT_W-1:0] cnt_nx;
  logic [CNT_W-1:0] last_edge;

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_s;
  end

  always_comb begin
    edge_evt  = run && (sck_s != sck_d);
    odd_edge  = (sck_d == cfg.cpol);
    cap_evt   = edge_evt && (odd_edge != cfg.cpha);
    shf_evt   = edge_evt && (odd_edge == cfg.cpha) && !(cfg.cpha && edge_cnt == '0);
    cnt_nx    = edge_cnt + CNT_W'(1);
    last_edge = cfg.wide ? LAST_WIDE : LAST_NARROW;
    done_evt  = edge_evt && (cnt_nx == last_edge);
  end

  always_ff @(posedge clk) begin
    if (rst)              edge_cnt <= '0;
    else if (frame_start) edge_cnt <= '0;
    else if (edge_evt)    edge_cnt <= cnt_nx;
  end
endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift
  import spi_slv_pkg::*;
#(
  parameter int W_WIDE   = 16,
  parameter int W_NARROW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [W_WIDE-1:0] load_word,
  input  logic              cap_evt,
  input  logic              shf_evt,
  input  logic              done_evt,
  input  logic              mosi_s,
  input  spi_cfg_t          cfg,
  output logic              out_bit,
  output logic [W_WIDE-1:0] word_out
);
  localparam logic [W_WIDE-1:0] NARROW_MASK =
    {{(W_WIDE-W_NARROW){1'b0}}, {W_NARROW{1'b1}}};

  logic [W_WIDE-1:0] sreg;
  logic [W_WIDE-1:0] sreg_nx;
  logic              hold;
  logic              commit_bit;

  function automatic logic [W_WIDE-1:0] shift_in(
    input logic [W_WIDE-1:0] v, input logic b, input logic lsbf, input logic wd);
    logic [W_WIDE-1:0] r;
    if (!lsbf) begin
      r = {v[W_WIDE-2:0], b};
    end else begin
      r = v >> 1;
      if (wd) r[W_WIDE-1]   = b;
      else    r[W_NARROW-1] = b;
    end
    return r;
  endfunction

  always_comb begin
    commit_bit = cap_evt ? mosi_s : hold;
    sreg_nx    = shift_in(sreg, commit_bit, cfg.lsb_first, cfg.wide);
    word_out   = cfg.wide ? sreg_nx : (sreg_nx & NARROW_MASK);
    if (cfg.lsb_first) out_bit = sreg[0];
    else if (cfg.wide) out_bit = sreg[W_WIDE-1];
    else               out_bit = sreg[W_NARROW-1];
  end

  always_ff @(posedge clk) begin
    if (rst)          hold <= 1'b0;
    else if (cap_evt) hold <= mosi_s;
  end

  always_ff @(posedge clk) begin
    if (rst)                      sreg <= '0;
    else if (load)                sreg <= load_word;
    else if (shf_evt || done_evt) sreg <= sreg_nx;
  end
endmodule

// File: rtl/spi_slave_xfer.sv
module spi_slave_xfer
  import spi_slv_pkg::*;
#(
  parameter int W_WIDE      = 16,
  parameter int W_NARROW    = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(2*W_WIDE+1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic              cfg_wide,
  input  logic [W_WIDE-1:0] tx_word,
  input  logic              tx_load,
  input  logic              done_clr,
  input  logic              sck_in,
  input  logic              mosi_in,
  input  logic              ss_n_in,
  output logic [W_WIDE-1:0] rx_word,
  output logic              rx_done,
  output logic              miso_out,
  output logic              miso_oe
);
  logic              sck_s, mosi_s, ss_s, ss_d;
  logic              frame_start;
  logic              active, sel, seen_edge;
  spi_cfg_t          cfg_q;
  logic [W_WIDE-1:0] tx_buf;
  logic              edge_evt, cap_evt, shf_evt, done_evt;
  logic [CNT_W-1:0]  edge_cnt;
  logic              out_bit;
  logic [W_WIDE-1:0] word_out;

  spi_slv_sync #(.STAGES(SYNC_STAGES), .N(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .d({ss_n_in, mosi_in, sck_in}),
    .q({ss_s, mosi_s, sck_s})
  );

  always_ff @(posedge clk) begin
    if (rst) ss_d <= 1'b1;
    else     ss_d <= ss_s;
  end
  assign frame_start = ss_d && !ss_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (frame_start) begin
      cfg_q.cpol      <= cfg_cpol;
      cfg_q.cpha      <= cfg_cpha;
      cfg_q.lsb_first <= cfg_lsb_first;
      cfg_q.wide      <= cfg_wide;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          tx_buf <= '0;
    else if (tx_load) tx_buf <= tx_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      sel       <= 1'b0;
      seen_edge <= 1'b0;
    end else if (ss_s) begin
      active    <= 1'b0;
      sel       <= 1'b0;
      seen_edge <= 1'b0;
    end else if (frame_start) begin
      active    <= 1'b1;
      sel       <= 1'b1;
      seen_edge <= 1'b0;
    end else begin
      if (done_evt) active    <= 1'b0;
      if (edge_evt) seen_edge <= 1'b1;
    end
  end

  spi_slv_edge #(.W_WIDE(W_WIDE), .W_NARROW(W_NARROW)) u_edge (
    .clk(clk), .rst(rst), .sck_s(sck_s), .frame_start(frame_start),
    .run(active), .cfg(cfg_q),
    .edge_evt(edge_evt), .cap_evt(cap_evt), .shf_evt(shf_evt),
    .done_evt(done_evt), .edge_cnt(edge_cnt)
  );

  spi_slv_shift #(.W_WIDE(W_WIDE), .W_NARROW(W_NARROW)) u_shift (
    .clk(clk), .rst(rst), .load(frame_start), .load_word(tx_buf),
    .cap_evt(cap_evt), .shf_evt(shf_evt), .done_evt(done_evt),
    .mosi_s(mosi_s), .cfg(cfg_q), .out_bit(out_bit), .word_out(word_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_word <= '0;
      rx_done <= 1'b0;
    end else begin
      if (done_evt) rx_word <= word_out;
      if (done_evt)      rx_done <= 1'b1;
      else if (done_clr) rx_done <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      miso_out <= 1'b0;
      miso_oe  <= 1'b0;
    end else begin
      miso_oe  <= sel && (!cfg_q.cpha || seen_edge);
      miso_out <= sel ? out_bit : 1'b0;
    end
  end
endmodule

// File: rtl/spi_slave_xfer_chk.sv
module spi_slave_xfer_chk
  import spi_slv_pkg::*;
#(
  parameter int W_WIDE   = 16,
  parameter int W_NARROW = 8,
  localparam int CNT_W   = $clog2(2*W_WIDE+1)
) (
  input logic              clk,
  input logic              rst,
  input logic              ss_n_in,
  input logic              miso_oe,
  input logic              rx_done,
  input logic              done_clr,
  input logic [W_WIDE-1:0] rx_word,
  input logic              done_evt,
  input logic              active,
  input logic              frame_start,
  input logic [CNT_W-1:0]  edge_cnt,
  input spi_cfg_t          cfg_q
);
  AST_OE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ss_n_in && $past(ss_n_in) && $past(ss_n_in, 2) && $past(ss_n_in, 3) && $past(ss_n_in, 4))
      |-> !miso_oe); // R2
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !done_clr) |=> rx_done); // R9
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (done_clr && !done_evt) |=> !rx_done); // R9
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_evt |=> $stable(rx_word)); // R8
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_done) |-> $past(done_evt)); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    edge_cnt <= (cfg_q.wide ? CNT_W'(2*W_WIDE) : CNT_W'(2*W_NARROW))); // R8
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (active && !frame_start) |=> $stable(cfg_q)); // R11
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done_evt |=> !active); // R13
endmodule

bind spi_slave_xfer spi_slave_xfer_chk #(.W_WIDE(W_WIDE), .W_NARROW(W_NARROW)) u_chk (
  .clk(clk), .rst(rst), .ss_n_in(ss_n_in), .miso_oe(miso_oe),
  .rx_done(rx_done), .done_clr(done_clr), .rx_word(rx_word),
  .done_evt(done_evt), .active(active), .frame_start(frame_start),
  .edge_cnt(edge_cnt), .cfg_q(cfg_q)
);

// File: tb/spi_slave_xfer_bench.sv
`timescale 1ns/1ps
module spi_slave_xfer_bench;
  localparam int H = 8;

  logic clk = 0;
  logic rst = 1;
  logic cpol = 0, cpha = 0, lsbf = 0, wide = 0;
  logic [15:0] txw = 0;
  logic txl = 0, clr = 0;
  logic sck = 0, mosi = 0, ssn = 1;
  logic [15:0] rxw;
  logic rxd, miso, oe;

  int n_chk = 0, n_bad = 0, ss_hi = 0;
  bit finished = 0;
  logic [15:0] exp_rx = 0;
  logic        exp_done = 0;

  always #2.5 clk = ~clk;

  spi_slave_xfer u_spi_slave_xfer (
    .clk(clk), .rst(rst), .cfg_cpol(cpol), .cfg_cpha(cpha),
    .cfg_lsb_first(lsbf), .cfg_wide(wide), .tx_word(txw), .tx_load(txl),
    .done_clr(clr), .sck_in(sck), .mosi_in(mosi), .ss_n_in(ssn),
    .rx_word(rxw), .rx_done(rxd), .miso_out(miso), .miso_oe(oe)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int idx(input bit l, input int n, input int k);
    return l ? k : n - 1 - k;
  endfunction

  // per-clock comparison of the release rule
  always @(negedge clk) begin
    if (ssn) ss_hi++; else ss_hi = 0;
    if (!rst && ss_hi >= 6) chk("R2 oe released while deselected", {15'd0, oe}, 16'd0);
  end

  task automatic frame(input bit p, input bit h, input bit l, input bit w,
                       input logic [15:0] tw, input logic [15:0] mw, input int nedges,
                       input bit do_load, input bit do_tx2, input logic [15:0] tw2,
                       input bit flip, input bit clr_last, input int extra);
    int n;
    string ptag;
    n = w ? 16 : 8;
    ptag = h ? "R4" : "R3";
    cpol = p; cpha = h; lsbf = l; wide = w; sck = p;
    if (do_load) begin txw = tw; txl = 1; waitn(1); txl = 0; end
    waitn(2);
    mosi = h ? 1'b0 : mw[idx(l, n, 0)];
    ssn = 0;
    waitn(H);
    if (h) chk("R4 oe low before first edge", {15'd0, oe}, 16'd0);
    else   chk("R3 oe high after select", {15'd0, oe}, 16'd1);
    for (int e = 1; e <= nedges; e++) begin
      bit capture;
      int k;
      capture = h ? (e % 2 == 0) : (e % 2 == 1);
      k = h ? e / 2 - 1 : (e - 1) / 2;
      if (capture && e <= 2 * n) begin
        chk($sformatf("%s/R5/R6/R7/R12 miso bit %0d", ptag, k), {15'd0, miso},
            {15'd0, tw[idx(l, n, k)]});
        chk($sformatf("%s oe during frame", ptag), {15'd0, oe}, 16'd1);
      end
      if (flip && e == 3) begin
        cpol = !p; cpha = !h; lsbf = !l; wide = !w;
      end
      sck = ~sck;
      if (!h && e % 2 == 0 && e / 2 < n) mosi = mw[idx(l, n, e / 2)];
      if (h && e % 2 == 1 && (e - 1) / 2 < n) mosi = mw[idx(l, n, (e - 1) / 2)];
      if (clr_last && e == 2 * n) begin
        waitn(2); clr = 1; waitn(1); clr = 0; waitn(H - 3);
      end else if (do_tx2 && e == 2) begin
        waitn(1); txw = tw2; txl = 1; waitn(1); txl = 0; waitn(H - 2);
      end else begin
        waitn(H);
      end
    end
    if (nedges >= 2 * n) begin
      exp_rx = mw;
      exp_done = 1;
    end
    if (extra > 0) begin
      chk("R8 done before extra edges", {15'd0, rxd}, 16'd1);
      clr = 1; waitn(1); clr = 0; exp_done = 0;
      for (int x = 0; x < extra; x++) begin
        sck = ~sck; mosi = ~mosi; waitn(H);
      end
      chk("R13 no completion from extra edges", {15'd0, rxd}, 16'd0);
    end
    ssn = 1;
    waitn(8);
    cpol = p; cpha = h; lsbf = l; wide = w;
    chk("R6/R7/R8/R10/R11 rx_word", rxw, exp_rx);
    chk("R8/R9/R10 rx_done", {15'd0, rxd}, {15'd0, exp_done});
  endtask

  task automatic clear_done();
    clr = 1; waitn(1); clr = 0; waitn(1);
    exp_done = 0;
    chk("R9 done cleared", {15'd0, rxd}, 16'd0);
  endtask

  initial begin
    waitn(10);
    rst = 0;
    waitn(2);
    chk("R1 rx_word reset", rxw, 16'h0000);
    chk("R1 rx_done reset", {15'd0, rxd}, 16'd0);
    chk("R1 oe reset", {15'd0, oe}, 16'd0);

    frame(0, 0, 0, 1, 16'hA53C, 16'h1E87, 32, 1, 0, 0, 0, 0, 0);
    waitn(20);
    chk("R9 done stays set", {15'd0, rxd}, 16'd1);
    clear_done();
    frame(0, 1, 1, 0, 16'h005B, 16'h00C4, 16, 1, 0, 0, 0, 0, 0);
    frame(1, 0, 1, 1, 16'h9D21, 16'h4BF0, 32, 1, 0, 0, 0, 0, 0);
    frame(1, 1, 0, 0, 16'h00E6, 16'h0037, 16, 1, 0, 0, 0, 0, 0);
    frame(0, 1, 0, 1, 16'h1234, 16'h8001, 32, 1, 0, 0, 0, 0, 0);
    clear_done();
    // R10: select released after 7 edges
    frame(0, 0, 0, 1, 16'hFFFF, 16'h0F0F, 7, 1, 0, 0, 0, 0, 0);
    // R9: clear coincides with completion
    frame(1, 0, 0, 0, 16'h00AA, 16'h0055, 16, 1, 0, 0, 0, 1, 0);
    clear_done();
    // R11: configuration pins change mid-frame
    frame(0, 0, 1, 0, 16'h00C3, 16'h0096, 16, 1, 0, 0, 1, 0, 0);
    // R12: load during frame, then a frame with no new load
    frame(1, 1, 1, 1, 16'h5A5A, 16'h3C3C, 32, 1, 1, 16'h0F0F, 0, 0, 0);
    frame(0, 0, 0, 1, 16'h0F0F, 16'h7777, 32, 0, 0, 0, 0, 0, 0);
    // R13: edges after completion
    frame(0, 0, 0, 0, 16'h0081, 16'h0042, 16, 1, 0, 0, 0, 0, 4);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule